// File: doc/BRIEF.md
# ADC Hardware Trigger Router

This block sits between a set of event-producing peripherals and an ADC. It decides which hardware event starts a conversion, and it decides which of two conversion slots (A or B) that conversion uses. A slot-A conversion uses configuration set A and writes result register A. Slot B uses configuration set B and result register B. The router gives one conversion-start pulse together with one slot strobe. The ADC reads the strobe to choose the configuration set and the result register.

There are two routing modes. When `alt_en` is 1, a 4-bit code `src_sel` picks one of eleven single-bit event inputs, and the static bit `slot_sel` names the slot. When `alt_en` is 0, the event inputs are ignored. Channel 0 of timer 1 then starts slot-A conversions and channel 1 of timer 1 starts slot-B conversions. Every event line goes through a two-flop synchroniser and a rising-edge detector, so an event held high counts as a single event.

A small state machine issues the strobes. The states are:
- `ST_IDLE`: nothing is issued.
- `ST_FIRE_A`: the slot-A strobe and the trigger are issued.
- `ST_FIRE_B`: the slot-B strobe and the trigger are issued.
- `ST_FIRE_A_THEN_B`: the slot-A strobe and the trigger are issued, and a slot-B request is owed.

The transitions are:
- From `ST_IDLE`, `ST_FIRE_A` or `ST_FIRE_B`, a lone slot-A request goes to `ST_FIRE_A`.
- From the same states, a lone slot-B request goes to `ST_FIRE_B`.
- From the same states, simultaneous A and B requests go to `ST_FIRE_A_THEN_B`.
- From the same states, no request goes to `ST_IDLE`.
- `ST_FIRE_A_THEN_B` always goes to `ST_FIRE_B`.

The control inputs (`alt_en`, `src_sel`, `slot_sel`) are expected to come from a register that resets to zero. They should stay static while events are in flight.

Top module: `adc_trig_router`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it is released with all event inputs low, `conv_trig`, `pre_a` and `pre_b` are 0.
- R2: With `alt_en`=1, a rising edge on event input `evt_in[i]` gives exactly one trigger when `src_sel` maps to `i`. The mapping from `src_sel` to `i` is:
  - 0000 → 0 (external pin)
  - 0001 → 1 (comparator)
  - 0100 → 2, 0101 → 3 (periodic triggers 0 and 1)
  - 1000 → 4, 1001 → 5, 1010 → 6 (overflows of timers 0, 1 and 2)
  - 1100 → 7 (clock alarm)
  - 1101 → 8 (clock seconds)
  - 1110 → 9 (low-power timer)
  - 1111 → 10 (radio sequencer)
  
  The pulse appears in the third clock cycle after the input change, counting the synchroniser and edge detector. An edge on any unselected event input gives nothing.
- R3: With `alt_en`=1, `slot_sel`=0 asserts `pre_a`, and `slot_sel`=1 asserts `pre_b`. The strobe is asserted in the same cycle as `conv_trig`.
- R4: The reserved `src_sel` codes 0010, 0011, 0110, 0111 and 1011 never produce a trigger, even when every event input rises.
- R5: With `alt_en`=0, a rising edge on `tmr1_ch0` gives `conv_trig` with `pre_a`. A rising edge on `tmr1_ch1` gives `conv_trig` with `pre_b`. Each pulse lasts one cycle.
- R6: With `alt_en`=0, if both timer channels rise in the same cycle, slot A is issued first and slot B is issued in the next cycle.
- R7: The inputs of the inactive mode have no effect. In the timer-channel mode `evt_in` is ignored, and in the selected-event mode `tmr1_ch0` and `tmr1_ch1` are ignored.
- R8: An event input held high for many cycles gives exactly one trigger. Its falling edge gives none.
- R9: A slot strobe is never issued without `conv_trig`. Every `conv_trig` carries exactly one of `pre_a` or `pre_b`, so a strobe is never late relative to its trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alt_en | input | 1 | 1: routing by selected event; 0: routing by timer-1 channels |
| src_sel | input | 4 | Event select code for the selected-event mode |
| slot_sel | input | 1 | Slot for the selected-event mode (0 = A, 1 = B) |
| evt_in | input | 11 | Asynchronous event lines, indexed as in R2 |
| tmr1_ch0 | input | 1 | Timer 1 channel 0 event (slot A source) |
| tmr1_ch1 | input | 1 | Timer 1 channel 1 event (slot B source) |
| conv_trig | output | 1 | One-cycle conversion start |
| pre_a | output | 1 | One-cycle slot-A strobe |
| pre_b | output | 1 | One-cycle slot-B strobe |

## Verification
The assertions take for granted that the mode inputs stay steady while an event travels through the synchroniser. They also rely on the two timer channels not rising again in the cycle that follows a simultaneous rise. The edge detector guarantees that second point only as long as the mode does not change during that cycle. The bench respects both assumptions: it changes `alt_en`, `src_sel` and `slot_sel` only after the event lines have been low long enough for the pipeline to drain. It also drives every event line at the falling clock edge, holding it for several cycles, so each edge is seen cleanly once.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int NUM_SRC   = 11;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);

    typedef enum logic [1:0] {
        ST_IDLE          = 2'd0,
        ST_FIRE_A        = 2'd1,
        ST_FIRE_B        = 2'd2,
        ST_FIRE_A_THEN_B = 2'd3
    } fire_state_t;

    typedef struct packed {
        logic                 hit;
        logic [SRC_IDX_W-1:0] idx;
    } src_map_t;

    // Select code to event index; reserved codes return hit = 0.
    function automatic src_map_t map_select(input logic [3:0] code);
        src_map_t m;
        m.hit = 1'b1;
        m.idx = '0;
        unique case (code)
            4'b0000: m.idx = SRC_IDX_W'(0);
            4'b0001: m.idx = SRC_IDX_W'(1);
            4'b0100: m.idx = SRC_IDX_W'(2);
            4'b0101: m.idx = SRC_IDX_W'(3);
            4'b1000: m.idx = SRC_IDX_W'(4);
            4'b1001: m.idx = SRC_IDX_W'(5);
            4'b1010: m.idx = SRC_IDX_W'(6);
            4'b1100: m.idx = SRC_IDX_W'(7);
            4'b1101: m.idx = SRC_IDX_W'(8);
            4'b1110: m.idx = SRC_IDX_W'(9);
            4'b1111: m.idx = SRC_IDX_W'(10);
            default: m.hit = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int WIDTH  = 13,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise_o
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] shift_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shift_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                shift_q <= {shift_q[STAGES-2:0], din[g]};
                prev_q  <= shift_q[LAST];
            end
        end

        assign rise_o[g] = shift_q[LAST] & ~prev_q;

        // R8: a detected rise never lasts more than one cycle
        p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]);
    end

endmodule

// File: rtl/trig_src_mux.sv
module trig_src_mux
    import adc_trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alt_en,
    input  logic [3:0]         src_sel,
    input  logic               slot_sel,
    input  logic [NUM_SRC-1:0] evt_rise,
    input  logic [1:0]         ch_rise,
    output logic               req_a,
    output logic               req_b
);

    src_map_t sel_map;
    logic     sel_fire;

    always_comb begin
        sel_map  = map_select(src_sel);
        sel_fire = sel_map.hit && evt_rise[sel_map.idx];
        if (alt_en) begin
            req_a = sel_fire && !slot_sel;
            req_b = sel_fire && slot_sel;
        end else begin
            req_a = ch_rise[0];
            req_b = ch_rise[1];
        end
    end

    // R4: reserved codes stay silent
    p_reserved_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_en && (src_sel inside {4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1011}))
        |-> !(req_a || req_b));

    // R7: timer channels have no effect in selected-event mode
    p_alt_no_channels_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_en && evt_rise == '0) |-> !(req_a || req_b));

endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic req_b,
    output logic conv_trig,
    output logic pre_a,
    output logic pre_b
);

    fire_state_t st_q, st_d;

    always_comb begin
        st_d = ST_IDLE;
        unique case (st_q)
            ST_IDLE, ST_FIRE_A, ST_FIRE_B: begin
                if (req_a && req_b)  st_d = ST_FIRE_A_THEN_B;
                else if (req_a)      st_d = ST_FIRE_A;
                else if (req_b)      st_d = ST_FIRE_B;
                else                 st_d = ST_IDLE;
            end
            ST_FIRE_A_THEN_B:        st_d = ST_FIRE_B;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        conv_trig = 1'b0;
        pre_a     = 1'b0;
        pre_b     = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_FIRE_A, ST_FIRE_A_THEN_B: begin
                conv_trig = 1'b1;
                pre_a     = 1'b1;
            end
            ST_FIRE_B: begin
                conv_trig = 1'b1;
                pre_b     = 1'b1;
            end
        endcase
    end

    // R9: a trigger always carries exactly one slot strobe
    p_strobe_with_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_trig |-> ($countones({pre_a, pre_b}) == 1));

    p_no_lone_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_trig |-> (!pre_a && !pre_b));

    // R2/R5: a lone request is served on the next cycle
    p_lone_a_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_a && !req_b && st_q != ST_FIRE_A_THEN_B) |=> (conv_trig && pre_a));

    // R6: an owed B follows A
    p_b_after_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_a && req_b && st_q != ST_FIRE_A_THEN_B) |=> pre_a ##1 (pre_b && conv_trig));

endmodule

// File: rtl/adc_trig_router.sv
module adc_trig_router
    import adc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alt_en,
    input  logic [3:0]         src_sel,
    input  logic               slot_sel,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic               tmr1_ch0,
    input  logic               tmr1_ch1,
    output logic               conv_trig,
    output logic               pre_a,
    output logic               pre_b
);

    localparam int LINES = NUM_SRC + 2;

    logic [LINES-1:0] rise_all;
    logic             req_a;
    logic             req_b;

    trig_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({tmr1_ch1, tmr1_ch0, evt_in}),
        .rise_o (rise_all)
    );

    trig_src_mux u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .alt_en   (alt_en),
        .src_sel  (src_sel),
        .slot_sel (slot_sel),
        .evt_rise (rise_all[NUM_SRC-1:0]),
        .ch_rise  (rise_all[LINES-1:NUM_SRC]),
        .req_a    (req_a),
        .req_b    (req_b)
    );

    trig_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_a     (req_a),
        .req_b     (req_b),
        .conv_trig (conv_trig),
        .pre_a     (pre_a),
        .pre_b     (pre_b)
    );

    // R1: quiet in the cycle after reset release
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !conv_trig);

endmodule

// File: tb/adc_trig_router_test.sv
module adc_trig_router_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_en = 1'b0;
    logic [3:0]  src_sel = 4'd0;
    logic        slot_sel = 1'b0;
    logic [10:0] evt_in = '0;
    logic        tmr1_ch0 = 1'b0;
    logic        tmr1_ch1 = 1'b0;
    logic        conv_trig, pre_a, pre_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_trig_router uut (
        .clk(clk), .rst_n(rst_n), .alt_en(alt_en), .src_sel(src_sel),
        .slot_sel(slot_sel), .evt_in(evt_in), .tmr1_ch0(tmr1_ch0),
        .tmr1_ch1(tmr1_ch1), .conv_trig(conv_trig), .pre_a(pre_a), .pre_b(pre_b)
    );

    // Observation packed as {conv_trig, pre_a, pre_b}
    function automatic logic [2:0] obs();
        return {conv_trig, pre_a, pre_b};
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Drive lines at a falling edge, look at the 2nd, 3rd and 4th falling edges, then release
    task automatic drive_watch(input logic [10:0] ev, input logic [1:0] ch,
                               input logic [2:0] e1, input logic [2:0] e2, input string tag);
        @(negedge clk);
        evt_in = ev; tmr1_ch0 = ch[0]; tmr1_ch1 = ch[1];
        @(negedge clk);
        @(negedge clk);
        chk({tag, " early"}, obs(), 3'b000);
        @(negedge clk);
        chk(tag, obs(), e1);
        @(negedge clk);
        chk({tag, " next"}, obs(), e2);
        evt_in = '0; tmr1_ch0 = 1'b0; tmr1_ch1 = 1'b0;
        repeat (4) @(negedge clk);
        chk({tag, " fall R8"}, obs(), 3'b000);
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", obs(), 3'b000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 after release", obs(), 3'b000);
    endtask

    task automatic t_alt_codes_r2_r3();
        logic [3:0] codes [11] = '{4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b1000, 4'b1001,
                                   4'b1010, 4'b1100, 4'b1101, 4'b1110, 4'b1111};
        alt_en = 1'b1;
        for (int i = 0; i < 11; i++) begin
            src_sel  = codes[i];
            slot_sel = i[0];
            drive_watch(11'(1) << i, 2'b00, slot_sel ? 3'b101 : 3'b110, 3'b000, "R2/R3 selected event");
        end
    endtask

    task automatic t_alt_wrong_src_r2();
        alt_en = 1'b1; src_sel = 4'b0001; slot_sel = 1'b0;
        drive_watch(~11'b10, 2'b00, 3'b000, 3'b000, "R2 unselected events");
    endtask

    task automatic t_reserved_r4();
        logic [3:0] rsv [5] = '{4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1011};
        alt_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            src_sel = rsv[i];
            drive_watch('1, 2'b00, 3'b000, 3'b000, "R4 reserved code");
        end
    endtask

    task automatic t_alt_ignores_ch_r7();
        alt_en = 1'b1; src_sel = 4'b0000;
        drive_watch('0, 2'b11, 3'b000, 3'b000, "R7 channels in selected mode");
    endtask

    task automatic t_channels_r5();
        alt_en = 1'b0; src_sel = 4'b0000; slot_sel = 1'b1;
        drive_watch('0, 2'b01, 3'b110, 3'b000, "R5 channel 0");
        drive_watch('0, 2'b10, 3'b101, 3'b000, "R5 channel 1");
    endtask

    task automatic t_chan_mode_ignores_evt_r7();
        alt_en = 1'b0; src_sel = 4'b0000;
        drive_watch('1, 2'b00, 3'b000, 3'b000, "R7 events in channel mode");
    endtask

    task automatic t_both_r6();
        alt_en = 1'b0;
        drive_watch('0, 2'b11, 3'b110, 3'b101, "R6 A then B");
    endtask

    task automatic t_held_r8_r9();
        int n_trig = 0;
        int n_pre = 0;
        alt_en = 1'b1; src_sel = 4'b1110; slot_sel = 1'b0;
        @(negedge clk);
        evt_in = 11'(1) << 9;
        repeat (20) begin
            @(negedge clk);
            n_trig += int'(conv_trig);
            n_pre  += int'(pre_a) + int'(pre_b);
        end
        evt_in = '0;
        repeat (6) begin
            @(negedge clk);
            n_trig += int'(conv_trig);
            n_pre  += int'(pre_a) + int'(pre_b);
        end
        chk("R8 held input pulses", 3'(n_trig), 3'd1);
        chk("R9 strobes per trigger", 3'(n_pre), 3'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_r1();
        t_alt_codes_r2_r3();
        t_alt_wrong_src_r2();
        t_reserved_r4();
        t_alt_ignores_ch_r7();
        t_channels_r5();
        t_chan_mode_ignores_evt_r7();
        t_both_r6();
        t_held_r8_r9();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule